// File: doc/BRIEF.md
# Dual-Channel Pipelined Converter Digital Correction

This block sits behind the analog core of a two-channel (I and Q) pipelined converter. For every sample, each channel's core makes eight coarse 2-bit decisions, each with one bit of redundancy, in a chain of front stages, followed by a final 2-bit flash decision. Neighbouring stages work on opposite clock phases, so the decisions that belong to one sample arrive spread over four and a half clock periods. The block gathers them, lines them up on one rising edge, and merges them with a one-bit overlap into a 10-bit offset-binary word per channel.

Odd-numbered stages are captured on the falling edge and then retimed to the rising edge. After that, per-stage delay lines of different lengths bring every stage's code to the same cycle. An adder with saturation then forms the final word. A warm-up counter keeps the valid flag low after reset until the pipeline has filled and settled.

The output is a free-running stream. A new word leaves on every rising edge, and there is no ready input, because the converter cannot pause its sampling. Once `word_valid` is high, the consumer must accept a word on every cycle. Both channels share the clock, the valid flag and the latency.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Each channel's code bus carries stage k (k = 1..9) in bits [2k-1:2k-2]. Stage 1 is in bits [1:0]. The final flash stage 9 is in bits [17:16].
- R2: The code of stage k for the sample taken at rising edge n is captured at the clock edge k half-periods after that rising edge. Odd stages (1, 3, 5, 7, 9) are therefore taken on falling edges and even stages on rising edges.
- R3: The corrected value is the sum over k = 1..8 of the stage-k code times 2^(9-k), plus the stage-9 code. Adjacent stage words overlap by one bit.
- R4: Front-stage codes are normally 00, 01 or 10. A code of 11 still enters the sum. Any sum above 1023 is output as 1023 (all ones). Every term is non-negative, so the output never wraps below 0.
- R5: The word for the sample taken at rising edge n is on the outputs just after rising edge n+6. From then on, a new word follows after every rising edge, with no back-pressure.
- R6: The I and Q words come from their own code buses only. They change on the same edge with the same latency.
- R7: `word_valid` is low while reset is high and for the first 19 rising edges after reset goes low. It goes high after the 20th such edge and stays high until the next reset.
- R8: A rising edge with the synchronous active-high reset asserted clears the delay lines, both data words (to 0) and the warm-up counter.
- R9: The output is offset binary. All zeros is negative full scale, all ones is positive full scale, and 1000000000 (512) is the code just above mid-scale, with 511 just below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; both edges capture stage codes |
| rst | input | 1 | Synchronous active-high reset |
| i_stage_codes | input | 18 | I-channel stage codes, stage k in bits [2k-1:2k-2] |
| q_stage_codes | input | 18 | Q-channel stage codes, same layout |
| i_word | output | 10 | Corrected I-channel word, offset binary |
| q_word | output | 10 | Corrected Q-channel word, offset binary |
| word_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
A delay line of the wrong length, or a stage captured on the wrong edge, mixes one stage's contribution from a neighbouring sample into the sum. Independent per-sample codes then produce a wrong word six edges after the affected sample, within a few cycles of the first valid word. A missing clamp shows up only when a front stage reports 11 with a large total, which appears as a small wrapped word on those samples. A warm-up counter error moves the rising edge of `word_valid` away from the 20th edge after reset, or makes the flag drop while running. I/Q cross-coupling shows up as soon as the two channels are given different codes.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int CODE_W           = 2;
  localparam int NUM_CH           = 2;
  localparam int DEF_FRONT_STAGES = 8;
  localparam int DEF_WARMUP       = 20;

  // Posedge registers a stage needs so that every stage of one sample
  // lands on the same rising edge ((total+1)/2 edges after sampling).
  function automatic int align_depth(int total, int k);
    return (total + 1) / 2 - (k + 1) / 2 + 1;
  endfunction
endpackage

// File: rtl/code_delay.sv
module code_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/stage_deskew.sv
module stage_deskew
  import adc_corr_pkg::*;
#(
  parameter int FRONT_STAGES = DEF_FRONT_STAGES,
  localparam int TOTAL = FRONT_STAGES + 1,
  localparam int BUS_W = TOTAL * CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] codes_i,
  output logic [BUS_W-1:0] aligned_o
);
  for (genvar k = 1; k <= TOTAL; k++) begin : g_stage
    localparam int DEPTH = align_depth(TOTAL, k);
    logic [CODE_W-1:0] feed;

    if (k % 2 == 1) begin : g_fall
      // odd stage: present around the falling edge, caught there first
      logic [CODE_W-1:0] fall_q;
      always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= codes_i[(k-1)*CODE_W +: CODE_W];
      end
      assign feed = fall_q;
    end else begin : g_rise
      assign feed = codes_i[(k-1)*CODE_W +: CODE_W];
    end

    code_delay #(.W(CODE_W), .DEPTH(DEPTH)) u_dly (
      .clk (clk),
      .rst (rst),
      .d_i (feed),
      .q_o (aligned_o[(k-1)*CODE_W +: CODE_W])
    );
  end

  // R8: a reset edge empties every alignment line
  a_r8_lines_clear: assert property (@(posedge clk)
    rst |=> (aligned_o == '0));
endmodule

// File: rtl/overlap_sum.sv
module overlap_sum
  import adc_corr_pkg::*;
#(
  parameter int FRONT_STAGES = DEF_FRONT_STAGES,
  localparam int TOTAL = FRONT_STAGES + 1,
  localparam int BUS_W = TOTAL * CODE_W,
  localparam int OUT_W = FRONT_STAGES + 2,
  localparam int SUM_W = OUT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] aligned_i,
  output logic [OUT_W-1:0] word_o
);
  localparam logic [OUT_W-1:0] TOP_CODE = '1;

  logic [SUM_W-1:0] sum_w;
  logic             over_w;

  // stage k weighs 2^(TOTAL-k): each code's upper bit lands on the
  // lower bit of the stage before it
  always_comb begin
    sum_w = '0;
    for (int k = 1; k <= TOTAL; k++) begin
      sum_w = sum_w + (SUM_W'(aligned_i[(k-1)*CODE_W +: CODE_W]) << (TOTAL - k));
    end
  end

  assign over_w = (sum_w > SUM_W'(TOP_CODE));

  always_ff @(posedge clk) begin
    if (rst)         word_o <= '0;
    else if (over_w) word_o <= TOP_CODE;
    else             word_o <= sum_w[OUT_W-1:0];
  end

  // R3: an in-range sum reaches the word unchanged one edge later
  a_r3_sum_passes: assert property (@(posedge clk) disable iff (rst)
    !over_w |=> (word_o == OUT_W'($past(sum_w))));

  // R4: an oversized sum saturates rather than wrapping
  a_r4_saturates: assert property (@(posedge clk) disable iff (rst)
    over_w |=> (word_o == TOP_CODE));
endmodule

// File: rtl/warmup_gate.sv
module warmup_gate
  import adc_corr_pkg::*;
#(
  parameter int WARMUP = DEF_WARMUP,
  localparam int CNT_W = $clog2(WARMUP + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic valid_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (cnt_q != CNT_W'(WARMUP)) cnt_q <= cnt_q + 1'b1;
  end

  assign valid_o = (cnt_q == CNT_W'(WARMUP));

  // R7: the flag only rises on the edge that completes the warm-up count
  a_r7_rise_on_count: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> ($past(cnt_q) == CNT_W'(WARMUP - 1)));

  // R7: once high, the flag stays high until reset
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> valid_o);

  // R7/R8: a reset edge drops the flag
  a_r7_reset_drops: assert property (@(posedge clk)
    rst |=> !valid_o);
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector
  import adc_corr_pkg::*;
#(
  parameter int FRONT_STAGES = DEF_FRONT_STAGES,
  parameter int WARMUP       = DEF_WARMUP,
  localparam int TOTAL = FRONT_STAGES + 1,
  localparam int BUS_W = TOTAL * CODE_W,
  localparam int OUT_W = FRONT_STAGES + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] i_stage_codes,
  input  logic [BUS_W-1:0] q_stage_codes,
  output logic [OUT_W-1:0] i_word,
  output logic [OUT_W-1:0] q_word,
  output logic             word_valid
);
  logic [NUM_CH-1:0][BUS_W-1:0] raw_codes;
  logic [NUM_CH-1:0][BUS_W-1:0] lined_codes;
  logic [NUM_CH-1:0][OUT_W-1:0] ch_words;

  assign raw_codes[0] = i_stage_codes;
  assign raw_codes[1] = q_stage_codes;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    stage_deskew #(.FRONT_STAGES(FRONT_STAGES)) u_deskew (
      .clk       (clk),
      .rst       (rst),
      .codes_i   (raw_codes[ch]),
      .aligned_o (lined_codes[ch])
    );

    overlap_sum #(.FRONT_STAGES(FRONT_STAGES)) u_sum (
      .clk       (clk),
      .rst       (rst),
      .aligned_i (lined_codes[ch]),
      .word_o    (ch_words[ch])
    );
  end

  warmup_gate #(.WARMUP(WARMUP)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .valid_o (word_valid)
  );

  assign i_word = ch_words[0];
  assign q_word = ch_words[1];
endmodule

// File: tb/pipe_adc_corrector_bench.sv
module pipe_adc_corrector_bench;
  localparam int CLK_PERIOD = 20;
  localparam int NSAMP      = 700;
  localparam int WARM       = 20;
  localparam int LAT        = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] i_codes;
  logic [17:0] q_codes;
  logic [9:0]  i_word;
  logic [9:0]  q_word;
  logic        word_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk           (clk),
    .rst           (rst),
    .i_stage_codes (i_codes),
    .q_stage_codes (q_codes),
    .i_word        (i_word),
    .q_word        (q_word),
    .word_valid    (word_valid)
  );

  logic [17:0] icode [NSAMP];
  logic [17:0] qcode [NSAMP];
  bit          directed [NSAMP];
  int          total   = 0;
  int          bad     = 0;
  int          pos_idx = -1;

  // R1 layout: stage k in bits [2k-1:2k-2]; front stages share a value here
  function automatic logic [17:0] uniform_code(int front, int flash);
    logic [17:0] c;
    for (int k = 1; k <= 8; k++) c[(k-1)*2 +: 2] = 2'(front);
    c[17:16] = 2'(flash);
    return c;
  endfunction

  function automatic logic [17:0] rand_code(bit allow_over);
    logic [17:0] c;
    for (int k = 1; k <= 8; k++)
      c[(k-1)*2 +: 2] = allow_over ? 2'($urandom_range(3, 0)) : 2'($urandom_range(2, 0));
    c[17:16] = 2'($urandom_range(3, 0));
    return c;
  endfunction

  function automatic int raw_sum(logic [17:0] c);
    int s = 0;
    for (int k = 1; k <= 8; k++) s += int'(c[(k-1)*2 +: 2]) * (1 << (9 - k));
    s += int'(c[17:16]);
    return s;
  endfunction

  function automatic int ref_word(logic [17:0] c);
    int s = raw_sum(c);
    return (s > 1023) ? 1023 : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2: stage k of sample n is driven a quarter period before edge 2n+k
  task automatic drive_edge(int e);
    for (int k = 1; k <= 9; k++) begin
      int t = e - k;
      if (t >= 0 && (t % 2) == 0) begin
        int n = t / 2;
        i_codes[(k-1)*2 +: 2] = (n < NSAMP) ? icode[n][(k-1)*2 +: 2] : 2'b00;
        q_codes[(k-1)*2 +: 2] = (n < NSAMP) ? qcode[n][(k-1)*2 +: 2] : 2'b00;
      end
    end
  endtask

  initial begin
    int p = -1;
    i_codes = '0;
    q_codes = '0;
    forever begin
      @(posedge clk);
      p++;
      #(CLK_PERIOD/4);
      drive_edge(2*p + 1);
      @(negedge clk);
      #(CLK_PERIOD/4);
      drive_edge(2*p + 2);
    end
  end

  // behavioural reference, compared after every rising edge
  initial begin
    int wc = 0;
    forever begin
      int    n;
      string tg;
      @(posedge clk);
      pos_idx++;
      if (rst) wc = 0;
      else if (wc < WARM) wc++;
      #(CLK_PERIOD/4);
      if (rst) begin
        check("R8 reset i_word", int'(i_word), 0);
        check("R8 reset q_word", int'(q_word), 0);
        check("R8 R7 reset word_valid", int'(word_valid), 0);
      end else begin
        check("R7 word_valid", int'(word_valid), int'(wc == WARM));
        n = pos_idx - LAT;
        if (wc == WARM && n >= 0 && n < NSAMP) begin
          tg = $sformatf("R1 R2 R3 R5 R6 ch=I sample=%0d", n);
          if (raw_sum(icode[n]) > 1023) tg = {tg, " R4"};
          if (directed[n]) tg = {tg, " R9"};
          check(tg, int'(i_word), ref_word(icode[n]));
          tg = $sformatf("R1 R2 R3 R5 R6 ch=Q sample=%0d", n);
          if (raw_sum(qcode[n]) > 1023) tg = {tg, " R4"};
          if (directed[n]) tg = {tg, " R9"};
          check(tg, int'(q_word), ref_word(qcode[n]));
        end
      end
    end
  end

  initial begin
    for (int n = 0; n < NSAMP; n++) begin
      directed[n] = 1'b0;
      icode[n] = rand_code(n >= 110 && n < 250);
      qcode[n] = rand_code(n >= 150 && n < 300);
    end
    // R9 scale points: 0, 1023, 512, 511; R4 all-11 saturates to 1023
    icode[100] = uniform_code(0, 0);  qcode[100] = uniform_code(2, 3);
    icode[101] = uniform_code(2, 3);  qcode[101] = uniform_code(0, 0);
    icode[102] = 18'h00002;           qcode[102] = uniform_code(1, 1);
    icode[103] = uniform_code(1, 1);  qcode[103] = 18'h00002;
    icode[104] = uniform_code(3, 3);  qcode[104] = uniform_code(1, 0);
    for (int n = 100; n <= 104; n++) directed[n] = 1'b1;

    rst = 1'b1;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4) rst = 1'b0;
    wait (pos_idx >= 400);
    @(negedge clk);
    #(CLK_PERIOD/4) rst = 1'b1;   // R7/R8: mid-run reset and fresh warm-up
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4) rst = 1'b0;
    wait (pos_idx >= NSAMP + LAT + 2);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule